// File: doc/BRIEF.md
# Variable Range Register Codec

This block translates a memory range description into the pair of 64-bit range registers that hold it, and translates such a pair back into a range description. A range is given as a base page number, a size in pages (4 KiB pages) and an 8-bit memory type. In encode direction the block builds the base word and the mask word. A zero size yields the all-zero disable pattern. In decode direction it takes a base word and a mask word and recovers the base page, the size and the type. A mask that is not contiguous at its top end is repaired first, and a flag reports the repair. The physical address width `PHYS_W` is a parameter, and the page-number width is `PN_W = PHYS_W - 12`.

Each request is one cycle wide. It is qualified by `req_valid` and steered by `req_decode`. The result appears on registered outputs one clock later, together with `rsp_valid`. The response path is a small state machine that records what kind of answer is being presented. Its states are ST_IDLE (no response), ST_ENC_LIVE (encode of a non-zero size), ST_ENC_OFF (encode of a zero size), ST_DEC_LIVE (decode of a pair whose mask valid bit is set) and ST_DEC_OFF (decode of a pair whose valid bit is clear). Every clock the machine moves to the state chosen by the current request. It takes the transition "no request" to ST_IDLE, "encode, size non-zero" to ST_ENC_LIVE, "encode, size zero" to ST_ENC_OFF, "decode, valid bit set" to ST_DEC_LIVE and "decode, valid bit clear" to ST_DEC_OFF. Any state can reach any other in one step.

Top module: `vrr_codec`

## Requirements
- R1: `rsp_valid` is high in exactly the cycles that follow a cycle with `req_valid` high. `rsp_decode` then equals the `req_decode` value of that request (1 = decode, 0 = encode).
- R2: An encode with non-zero size gives a base word with bits [PHYS_W-1:12] equal to the base page and bits [7:0] equal to the type. All other bits are zero.
- R3: An encode with non-zero size gives a mask word with bits [PHYS_W-1:12] equal to the PN_W-bit two's complement of the size, and bit 11 (valid) set. All other bits are zero.
- R4: An encode with zero size gives a base word and a mask word that are both all zero.
- R5: A decode whose mask word has bit 11 clear returns base page 0, size 0, type 0 and a clear repair flag.
- R6: A decode with mask bit 11 set returns the base page from base word bits [PHYS_W-1:12] and the type from base word bits [7:0]. Base word bits [11:8], mask word bits [10:0] other than bit 11, and bits 63 down to PHYS_W of either word have no effect.
- R7: On a valid decode, the page mask is mask word bits [PHYS_W-1:12]. Every bit above its highest set bit is forced to one, and holes below that bit are kept. `out_mask_fixed` is high exactly when this changes the page mask.
- R8: On a valid decode, the size is the PN_W-bit two's complement of the repaired page mask. An all-zero page mask gives size 0 with no repair.
- R9: When `rsp_valid` is low, every data output is zero. An encode response shows zero decode fields, and a decode response shows zero register words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_decode | input | 1 | 1 = decode a register pair, 0 = encode a range |
| enc_base_pg | input | PN_W | Base page number to encode |
| enc_size_pg | input | PN_W | Size in pages to encode; 0 disables |
| enc_type | input | 8 | Memory type to encode |
| dec_base_word | input | 64 | Base register word to decode |
| dec_mask_word | input | 64 | Mask register word to decode |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_decode | output | 1 | Direction of the presented result |
| out_base_word | output | 64 | Encoded base register word |
| out_mask_word | output | 64 | Encoded mask register word |
| out_base_pg | output | PN_W | Decoded base page number |
| out_size_pg | output | PN_W | Decoded size in pages |
| out_type | output | 8 | Decoded memory type |
| out_mask_fixed | output | 1 | Decoded mask needed repair |

## Verification
The bench targets masks whose top bits are clear, which must be filled from the highest set bit upward. A design that filled from the lowest set bit would also close holes lower down, and that changes both the size and the flag. It also sends contiguous masks with interior holes, which must pass through unflagged, and an all-zero mask with the valid bit set, where a careless negation would raise the flag or report a wrong size. On the encode side, a zero size must zero both words. A design that still set the valid bit, or that leaked the base and type, fails R4. Decode requests carry junk in bits [11:8] and above the physical width, and back-to-back requests alternate direction, so leaked fields or a stale result from the previous request show up in the next cycle.

// File: rtl/vrr_pkg.sv
package vrr_pkg;

    localparam int WORD_W     = 64;
    localparam int PAGE_SHIFT = 12;
    localparam int VALID_BIT  = 11;
    localparam int TYPE_W     = 8;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ENC_LIVE = 3'd1,
        ST_ENC_OFF  = 3'd2,
        ST_DEC_LIVE = 3'd3,
        ST_DEC_OFF  = 3'd4
    } rsp_state_e;

endpackage

// File: rtl/vrr_encoder.sv
module vrr_encoder
    import vrr_pkg::*;
#(
    parameter int PHYS_W = 36,
    localparam int PN_W  = PHYS_W - PAGE_SHIFT
) (
    input  logic [PN_W-1:0]   base_pg,
    input  logic [PN_W-1:0]   size_pg,
    input  logic [TYPE_W-1:0] mem_type,
    output logic [WORD_W-1:0] base_word,
    output logic [WORD_W-1:0] mask_word
);

    localparam logic [PN_W-1:0] PG_ONE = PN_W'(1);

    logic [PN_W-1:0] size_neg;

    // two's complement of the page count gives the page mask
    assign size_neg = (~size_pg) + PG_ONE;

    always_comb begin
        base_word = '0;
        base_word[PHYS_W-1:PAGE_SHIFT] = base_pg;
        base_word[TYPE_W-1:0]          = mem_type;
    end

    always_comb begin
        mask_word = '0;
        mask_word[PHYS_W-1:PAGE_SHIFT] = size_neg;
        mask_word[VALID_BIT]           = 1'b1;
    end

endmodule

// File: rtl/vrr_mask_repair.sv
module vrr_mask_repair #(
    parameter int PN_W = 24
) (
    input  logic [PN_W-1:0] page_mask,
    output logic [PN_W-1:0] fixed_mask,
    output logic            was_fixed
);

    // hit_at_or_above[i] is set when any mask bit at position i or higher is one
    logic [PN_W:0] hit_at_or_above;

    assign hit_at_or_above[PN_W] = 1'b0;

    for (genvar i = PN_W - 1; i >= 0; i--) begin : g_chain
        assign hit_at_or_above[i] = hit_at_or_above[i+1] | page_mask[i];
        // a bit with nothing set above it lies above the top set bit
        assign fixed_mask[i] = page_mask[i] | (hit_at_or_above[0] & ~hit_at_or_above[i+1]);
    end

    assign was_fixed = (fixed_mask != page_mask);

endmodule

// File: rtl/vrr_decoder.sv
module vrr_decoder
    import vrr_pkg::*;
#(
    parameter int PHYS_W = 36,
    localparam int PN_W  = PHYS_W - PAGE_SHIFT
) (
    input  logic [WORD_W-1:0] base_word,
    input  logic [WORD_W-1:0] mask_word,
    output logic              entry_on,
    output logic [PN_W-1:0]   base_pg,
    output logic [PN_W-1:0]   size_pg,
    output logic [TYPE_W-1:0] mem_type,
    output logic              mask_fixed
);

    localparam logic [PN_W-1:0] PG_ONE = PN_W'(1);

    logic [PN_W-1:0] page_mask;
    logic [PN_W-1:0] repaired;
    logic            repair_hit;
    logic            unused_hi;
    logic            unused_low;

    assign entry_on  = mask_word[VALID_BIT];
    assign base_pg   = base_word[PHYS_W-1:PAGE_SHIFT];
    assign mem_type  = base_word[TYPE_W-1:0];
    assign page_mask = mask_word[PHYS_W-1:PAGE_SHIFT];

    vrr_mask_repair #(.PN_W(PN_W)) repair_i (
        .page_mask  (page_mask),
        .fixed_mask (repaired),
        .was_fixed  (repair_hit)
    );

    assign size_pg    = (~repaired) + PG_ONE;
    assign mask_fixed = repair_hit;

    assign unused_low = ^{base_word[VALID_BIT:TYPE_W], mask_word[VALID_BIT-1:0]};

    if (PHYS_W < WORD_W) begin : g_upper
        assign unused_hi = ^{base_word[WORD_W-1:PHYS_W], mask_word[WORD_W-1:PHYS_W]};
    end else begin : g_no_upper
        assign unused_hi = 1'b0;
    end

endmodule

// File: rtl/vrr_codec.sv
module vrr_codec
    import vrr_pkg::*;
#(
    parameter int PHYS_W = 36,
    localparam int PN_W  = PHYS_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_decode,
    input  logic [PN_W-1:0]   enc_base_pg,
    input  logic [PN_W-1:0]   enc_size_pg,
    input  logic [7:0]        enc_type,
    input  logic [63:0]       dec_base_word,
    input  logic [63:0]       dec_mask_word,
    output logic              rsp_valid,
    output logic              rsp_decode,
    output logic [63:0]       out_base_word,
    output logic [63:0]       out_mask_word,
    output logic [PN_W-1:0]   out_base_pg,
    output logic [PN_W-1:0]   out_size_pg,
    output logic [7:0]        out_type,
    output logic              out_mask_fixed
);

    rsp_state_e state_q, state_d;

    logic [WORD_W-1:0] enc_bw, enc_mw;
    logic              dec_on;
    logic [PN_W-1:0]   dec_bpg, dec_spg;
    logic [TYPE_W-1:0] dec_typ;
    logic              dec_fix;

    logic [WORD_W-1:0] bw_q, mw_q;
    logic [PN_W-1:0]   bpg_q, spg_q;
    logic [TYPE_W-1:0] typ_q;
    logic              fix_q;

    vrr_encoder #(.PHYS_W(PHYS_W)) enc_i (
        .base_pg   (enc_base_pg),
        .size_pg   (enc_size_pg),
        .mem_type  (enc_type),
        .base_word (enc_bw),
        .mask_word (enc_mw)
    );

    vrr_decoder #(.PHYS_W(PHYS_W)) dec_i (
        .base_word  (dec_base_word),
        .mask_word  (dec_mask_word),
        .entry_on   (dec_on),
        .base_pg    (dec_bpg),
        .size_pg    (dec_spg),
        .mem_type   (dec_typ),
        .mask_fixed (dec_fix)
    );

    // next response kind is chosen by the current request alone
    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;
        end else if (req_decode) begin
            state_d = dec_on ? ST_DEC_LIVE : ST_DEC_OFF;
        end else begin
            state_d = (enc_size_pg != '0) ? ST_ENC_LIVE : ST_ENC_OFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // result capture: both directions are latched, the state picks one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bw_q  <= '0;
            mw_q  <= '0;
            bpg_q <= '0;
            spg_q <= '0;
            typ_q <= '0;
            fix_q <= 1'b0;
        end else if (req_valid) begin
            bw_q  <= enc_bw;
            mw_q  <= enc_mw;
            bpg_q <= dec_bpg;
            spg_q <= dec_spg;
            typ_q <= dec_typ;
            fix_q <= dec_fix;
        end
    end

    always_comb begin
        rsp_valid      = 1'b0;
        rsp_decode     = 1'b0;
        out_base_word  = '0;
        out_mask_word  = '0;
        out_base_pg    = '0;
        out_size_pg    = '0;
        out_type       = '0;
        out_mask_fixed = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ENC_LIVE: begin
                rsp_valid     = 1'b1;
                out_base_word = bw_q;
                out_mask_word = mw_q;
            end
            ST_ENC_OFF: begin
                rsp_valid = 1'b1;
            end
            ST_DEC_LIVE: begin
                rsp_valid      = 1'b1;
                rsp_decode     = 1'b1;
                out_base_pg    = bpg_q;
                out_size_pg    = spg_q;
                out_type       = typ_q;
                out_mask_fixed = fix_q;
            end
            ST_DEC_OFF: begin
                rsp_valid  = 1'b1;
                rsp_decode = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/vrr_codec_chk.sv
module vrr_codec_chk #(
    parameter int PHYS_W = 36,
    localparam int PN_W  = PHYS_W - 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_decode,
    input logic [PN_W-1:0] enc_base_pg,
    input logic [PN_W-1:0] enc_size_pg,
    input logic [7:0]      enc_type,
    input logic [63:0]     dec_base_word,
    input logic [63:0]     dec_mask_word,
    input logic            rsp_valid,
    input logic            rsp_decode,
    input logic [63:0]     out_base_word,
    input logic [63:0]     out_mask_word,
    input logic [PN_W-1:0] out_base_pg,
    input logic [PN_W-1:0] out_size_pg,
    input logic [7:0]      out_type,
    input logic            out_mask_fixed
);

    assert_req_gives_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_req_no_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_dir_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_decode == $past(req_decode)));

    assert_enc_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_decode && enc_size_pg != '0) |=> (out_base_word[7:0] == $past(enc_type)));

    assert_enc_valid_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_decode && enc_size_pg != '0) |=> out_mask_word[11]);

    assert_enc_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_decode && enc_size_pg == '0) |=> (out_mask_word == '0 && out_base_word == '0));

    assert_dec_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_decode && !dec_mask_word[11]) |=>
        (out_base_pg == '0 && out_size_pg == '0 && out_type == '0 && !out_mask_fixed));

    assert_dec_type_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_decode && dec_mask_word[11]) |=> (out_type == $past(dec_base_word[7:0])));

    assert_top_set_no_fix_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_decode && dec_mask_word[PHYS_W-1]) |=> !out_mask_fixed);

    assert_fix_only_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_mask_fixed |-> (rsp_valid && rsp_decode));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (out_base_word == '0 && out_mask_word == '0 && out_size_pg == '0));

endmodule

bind vrr_codec vrr_codec_chk #(.PHYS_W(PHYS_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_decode     (req_decode),
    .enc_base_pg    (enc_base_pg),
    .enc_size_pg    (enc_size_pg),
    .enc_type       (enc_type),
    .dec_base_word  (dec_base_word),
    .dec_mask_word  (dec_mask_word),
    .rsp_valid      (rsp_valid),
    .rsp_decode     (rsp_decode),
    .out_base_word  (out_base_word),
    .out_mask_word  (out_mask_word),
    .out_base_pg    (out_base_pg),
    .out_size_pg    (out_size_pg),
    .out_type       (out_type),
    .out_mask_fixed (out_mask_fixed)
);

// File: tb/vrr_codec_tb_top.sv
module vrr_codec_tb_top;

    localparam int PHYS_W = 36;
    localparam int PN_W   = PHYS_W - 12;
    localparam logic [63:0] PNMASK = (64'd1 << PN_W) - 64'd1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_decode = 1'b0;
    logic [PN_W-1:0] enc_base_pg = '0;
    logic [PN_W-1:0] enc_size_pg = '0;
    logic [7:0]      enc_type = '0;
    logic [63:0]     dec_base_word = '0;
    logic [63:0]     dec_mask_word = '0;
    logic            rsp_valid, rsp_decode, out_mask_fixed;
    logic [63:0]     out_base_word, out_mask_word;
    logic [PN_W-1:0] out_base_pg, out_size_pg;
    logic [7:0]      out_type;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // expected values for the response visible in the next cycle
    logic        e_valid, e_dec, e_fix;
    logic [63:0] e_bw, e_mw, e_bpg, e_size, e_type;
    string       t_words, t_bw, t_mw, t_fields, t_size, t_fix;

    always #4 clk = ~clk;

    vrr_codec #(.PHYS_W(PHYS_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_decode     (req_decode),
        .enc_base_pg    (enc_base_pg),
        .enc_size_pg    (enc_size_pg),
        .enc_type       (enc_type),
        .dec_base_word  (dec_base_word),
        .dec_mask_word  (dec_mask_word),
        .rsp_valid      (rsp_valid),
        .rsp_decode     (rsp_decode),
        .out_base_word  (out_base_word),
        .out_mask_word  (out_mask_word),
        .out_base_pg    (out_base_pg),
        .out_size_pg    (out_size_pg),
        .out_type       (out_type),
        .out_mask_fixed (out_mask_fixed)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic set_idle_expect();
        e_valid = 0; e_dec = 0; e_fix = 0;
        e_bw = 0; e_mw = 0; e_bpg = 0; e_size = 0; e_type = 0;
        t_bw = "R9"; t_mw = "R9"; t_fields = "R9"; t_size = "R9"; t_fix = "R9";
    endtask

    task automatic compare_all();
        chk("R1", "rsp_valid", 64'(rsp_valid), 64'(e_valid));
        chk("R1", "rsp_decode", 64'(rsp_decode), 64'(e_dec));
        chk(t_bw, "base_word", out_base_word, e_bw);
        chk(t_mw, "mask_word", out_mask_word, e_mw);
        chk(t_fields, "base_pg", 64'(out_base_pg), e_bpg);
        chk(t_fields, "type", 64'(out_type), e_type);
        chk(t_size, "size_pg", 64'(out_size_pg), e_size);
        chk(t_fix, "mask_fixed", 64'(out_mask_fixed), 64'(e_fix));
    endtask

    task automatic drive_idle();
        req_valid = 0;
        set_idle_expect();
    endtask

    task automatic drive_enc(logic [63:0] bpg, logic [63:0] spg, logic [7:0] typ);
        req_valid = 1; req_decode = 0;
        enc_base_pg = bpg[PN_W-1:0]; enc_size_pg = spg[PN_W-1:0]; enc_type = typ;
        set_idle_expect();
        e_valid = 1;
        if ((spg & PNMASK) == 0) begin
            t_bw = "R4"; t_mw = "R4";
        end else begin
            t_bw = "R2"; t_mw = "R3";
            e_bw = ((bpg & PNMASK) << 12) | 64'(typ);
            e_mw = (((~spg + 64'd1) & PNMASK) << 12) | 64'h800;
        end
    endtask

    task automatic drive_dec(logic [63:0] bw, logic [63:0] mw);
        logic [63:0] pm, fixed;
        int top;
        req_valid = 1; req_decode = 1;
        dec_base_word = bw; dec_mask_word = mw;
        set_idle_expect();
        e_valid = 1; e_dec = 1;
        if (!mw[11]) begin
            t_fields = "R5"; t_size = "R5"; t_fix = "R5";
        end else begin
            t_fields = "R6"; t_size = "R8"; t_fix = "R7";
            e_bpg  = (bw >> 12) & PNMASK;
            e_type = bw & 64'hFF;
            pm = (mw >> 12) & PNMASK;
            top = -1;
            for (int i = 0; i < PN_W; i++) if (pm[i]) top = i;
            fixed = pm;
            if (top >= 0) for (int i = top + 1; i < PN_W; i++) fixed[i] = 1'b1;
            e_fix  = (fixed != pm);
            e_size = (~fixed + 64'd1) & PNMASK;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        set_idle_expect();
        repeat (3) @(negedge clk);
        compare_all();                       // reset state, R9
        rst_n = 1;

        @(negedge clk); compare_all(); drive_enc(64'h12345, 64'h100, 8'h06);          // R2 R3
        @(negedge clk); compare_all(); drive_enc(64'h0ABCD, 64'h0, 8'h05);            // R4
        @(negedge clk); compare_all(); drive_enc(64'hFFFFFF, 64'h1, 8'h00);           // R2 R3 edge
        @(negedge clk); compare_all(); drive_dec(64'hFFFF_FFFF_FFFF_FF06, 64'hFFFF_FFF0_0000_07FF); // R5
        @(negedge clk); compare_all(); drive_dec(64'hABC0_0012_3456_7F04, 64'h5A00_000F_FFF0_0FFF); // R6 R8 junk bits
        @(negedge clk); compare_all(); drive_dec(64'h0000_0000_0001_0001, 64'h0000_0000_00F0_0800); // R7 repair
        @(negedge clk); compare_all(); drive_dec(64'h0000_0000_0002_0006, 64'h0000_000F_F0F0_0800); // R7 holes kept
        @(negedge clk); compare_all(); drive_dec(64'h0000_0000_0003_0001, 64'h0000_0000_0000_0800); // R8 zero mask
        @(negedge clk); compare_all(); drive_dec(64'h0, 64'h0000_000F_FFFF_F800);     // R8 size one
        @(negedge clk); compare_all(); drive_idle();                                   // R1 R9
        @(negedge clk); compare_all(); drive_enc(64'h00800, 64'h800000, 8'h01);       // R3 top bit

        for (int n = 0; n < 400; n++) begin
            int sel;
            @(negedge clk);
            compare_all();
            sel = $urandom_range(0, 5);
            if (sel == 0) drive_idle();
            else if (sel == 1) drive_enc(64'($urandom), 64'($urandom_range(0, 3)), 8'($urandom));
            else if (sel == 2) drive_enc(64'($urandom), 64'($urandom), 8'($urandom));
            else if (sel == 3) drive_dec({$urandom, $urandom}, {$urandom, $urandom});
            else drive_dec({$urandom, $urandom},
                           ({$urandom, $urandom} >> $urandom_range(0, 30)) | 64'h800);
        end
        @(negedge clk); compare_all(); drive_idle();
        @(negedge clk); compare_all();

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule